// File: doc/BRIEF.md
# Serial Flash Auto-Increment Word Writer

This block programs an arbitrary byte range into a serial NOR flash that has an auto-address-increment word program command. A host pulses `start` with a start address and a byte count. The data bytes then arrive on a valid/ready stream. The block turns the range into a series of chip-select framed byte transfers on an SPI master's byte interface. A leading byte at an odd address goes out as a single-byte program. The aligned middle goes out as two-byte words. Only the first word carries the address; each later word sends its opcode and two data bytes. A byte left over at the end is written with its own write-enable, single-byte program and write-disable.

Every programming frame is followed by a status poll. One chip-select assertion sends the status opcode, then dummy bytes, until a received status byte has bit 0 clear. A poll that runs past a programmable cycle limit aborts the whole sequence. When it aborts, the block reports a timeout flag and the number of bytes already programmed.

The byte stream follows valid/ready rules. Once `din_valid` is raised it must stay high, with `din_data` stable, until `din_ready` is seen with it. `din_ready` is high only in a cycle where a data byte is being passed to the SPI master and `tx_ready` is high. A stream that stalls holds the SPI side with `tx_valid` low. The SPI master accepts a byte on `tx_valid && tx_ready`. For each accepted byte it returns one `rx_valid` pulse carrying the byte received in the same exchange.

Top module: `aai_flash_writer`

## Requirements
- R1: Command encodings: write-enable 0x06, write-disable 0x04, status read 0x05, single-byte program 0x02, word program 0xAD. Addresses go out as 3 bytes, most significant first, directly after the opcode. Poll dummy bytes are 0x00.
- R2: An accepted range starts with a status poll frame followed by one write-enable frame.
- R3: When the start address is odd, the first programming frame is 0x02, the address and one data byte. The working address then advances by one.
- R4: While two or more bytes remain, word frames are sent. The first word frame is 0xAD, the address and two data bytes. Every later word frame is 0xAD and two data bytes only.
- R5: After every programming frame a poll frame follows. It is 0x05, then one 0x00 byte per status byte, and it ends on the first received status byte whose bit 0 is 0.
- R6: After the word phase, even when it had no words, a write-disable frame and a poll frame are sent.
- R7: When one byte remains after that, the block sends write-enable, a single-byte program at the current address, a poll and a final write-disable.
- R8: A zero length raises `done` in the cycle after `start` and sends no frame.
- R9: When start address plus length exceeds `DEV_BYTES`, the range is rejected. `err_range` and `done` rise in the cycle after `start` and no frame is sent. A range that ends exactly at `DEV_BYTES` is accepted.
- R10: A poll still busy at a status byte returned after `poll_limit` or more cycles of that poll frame aborts the sequence. The block releases chip select, raises `err_timeout` and `done`, and leaves `bytes_done` equal to the data bytes of the programming frames already completed.
- R11: Each frame has its own chip-select assertion. Chip select is high for at least one cycle between frames, and no byte is offered while it is high.
- R12: Data bytes are consumed from the stream in order, exactly one per data byte sent. `din_ready` is high only while `tx_ready` is high inside a frame. A stalled stream holds `tx_valid` low.
- R13: `busy` is high from the cycle after an accepted `start` until the sequence ends. `done` is a one-cycle pulse with `busy` low. After reset the block is idle with chip select high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a range write (ignored while busy) |
| start_addr | input | 24 | First byte address |
| length | input | 24 | Number of bytes to program |
| poll_limit | input | 20 | Cycle limit for one status poll frame |
| din_valid | input | 1 | Stream data valid |
| din_data | input | 8 | Stream data byte |
| din_ready | output | 1 | Stream byte taken |
| spi_cs_n | output | 1 | Active-low chip select |
| tx_valid | output | 1 | Byte offered to SPI master |
| tx_data | output | 8 | Byte to shift out |
| tx_ready | input | 1 | SPI master accepts byte |
| rx_valid | input | 1 | Exchange finished, received byte valid |
| rx_data | input | 8 | Byte received during the exchange |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| err_range | output | 1 | Last request rejected for range |
| err_timeout | output | 1 | Last sequence aborted by poll timeout |
| bytes_done | output | 24 | Bytes programmed by the last sequence |

## Verification
Zero-length and out-of-range requests finish one clock after the `start` edge. The bench samples at the following falling edge and expects `done` there with a wait count of zero. Every other result depends on the master model's fixed latency: a byte is accepted, the receive pulse comes one clock later, and chip select rises one clock after the last receive. The bench therefore records each frame when chip select rises. That record is complete before the registered `done` pulse, and the bench compares the frame log, `bytes_done` and the flags at the first falling edge where `done` is high. It checks `done` low again one cycle later.

// File: rtl/aai_wr_pkg.sv
package aai_wr_pkg;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_BYTE = 8'h02;
  localparam logic [7:0] OP_WORD = 8'hAD;

  typedef struct packed {
    logic [7:0] op;
    logic       use_addr;
    logic [1:0] ndata;
    logic       poll;
  } frame_cmd_t;

  typedef enum logic [3:0] {
    SQ_IDLE, SQ_POLL0, SQ_WREN, SQ_ODD, SQ_ODD_POLL, SQ_WORD, SQ_WORD_POLL,
    SQ_WRDI, SQ_WRDI_POLL, SQ_TWREN, SQ_TAIL, SQ_TAIL_POLL, SQ_TWRDI
  } seq_state_t;

  typedef enum logic [1:0] {EN_IDLE, EN_SEND, EN_WAIT, EN_GAP} eng_state_t;
endpackage

// File: rtl/aai_frame_engine.sv
module aai_frame_engine
  import aai_wr_pkg::*;
#(
  parameter int ADDR_BYTES = 3,
  parameter int LIMIT_W    = 20
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    go,
  input  frame_cmd_t              cmd,
  input  logic [8*ADDR_BYTES-1:0] addr,
  input  logic [LIMIT_W-1:0]      limit,
  output logic                    fr_done,
  output logic                    fr_tout,
  output logic                    cs_n,
  output logic                    tx_valid,
  output logic [7:0]              tx_data,
  input  logic                    tx_ready,
  input  logic                    rx_valid,
  input  logic [7:0]              rx_data,
  input  logic                    din_valid,
  input  logic [7:0]              din_data,
  output logic                    din_ready
);
  localparam int ADDR_W = 8 * ADDR_BYTES;
  localparam int IDX_W  = $clog2(ADDR_BYTES + 4);

  eng_state_t        st;
  frame_cmd_t        cq;
  logic [ADDR_W-1:0] aq;
  logic [IDX_W-1:0]  idx;
  logic [LIMIT_W-1:0] pcnt;
  logic              tq;
  logic [IDX_W-1:0]  hdr_len, last_idx;
  logic              is_data;
  logic [ADDR_W-1:0] ash;

  always_comb begin
    hdr_len  = cq.use_addr ? IDX_W'(ADDR_BYTES + 1) : IDX_W'(1);
    last_idx = hdr_len + IDX_W'(cq.ndata) - IDX_W'(1);
    is_data  = !cq.poll && (idx >= hdr_len);
    ash      = aq >> (8 * (ADDR_BYTES - int'(idx)));
    if (idx == '0)        tx_data = cq.op;
    else if (cq.poll)     tx_data = 8'h00;
    else if (!is_data)    tx_data = ash[7:0];
    else                  tx_data = din_data;
  end

  assign tx_valid  = (st == EN_SEND) && (!is_data || din_valid);
  assign din_ready = (st == EN_SEND) && is_data && tx_ready;
  assign cs_n      = !((st == EN_SEND) || (st == EN_WAIT));
  assign fr_done   = (st == EN_GAP);
  assign fr_tout   = (st == EN_GAP) && tq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= EN_IDLE;
      cq   <= '0;
      aq   <= '0;
      idx  <= '0;
      pcnt <= '0;
      tq   <= 1'b0;
    end else begin
      if (cq.poll && (st == EN_SEND || st == EN_WAIT) && pcnt != '1)
        pcnt <= pcnt + 1'b1;
      unique case (st)
        EN_IDLE: if (go) begin
          cq   <= cmd;
          aq   <= addr;
          idx  <= '0;
          pcnt <= '0;
          tq   <= 1'b0;
          st   <= EN_SEND;
        end
        EN_SEND: if (tx_valid && tx_ready) st <= EN_WAIT;
        EN_WAIT: if (rx_valid) begin
          if (cq.poll) begin
            if (idx != '0 && !rx_data[0]) st <= EN_GAP;
            else if (idx != '0 && pcnt >= limit) begin
              tq <= 1'b1;
              st <= EN_GAP;
            end else begin
              idx <= IDX_W'(1);
              st  <= EN_SEND;
            end
          end else if (idx == last_idx) st <= EN_GAP;
          else begin
            idx <= idx + 1'b1;
            st  <= EN_SEND;
          end
        end
        default: st <= EN_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/aai_sequencer.sv
module aai_sequencer
  import aai_wr_pkg::*;
#(
  parameter int          ADDR_BYTES = 3,
  parameter int          LEN_W      = 24,
  parameter int unsigned DEV_BYTES  = 32'd1048576
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [8*ADDR_BYTES-1:0] start_addr,
  input  logic [LEN_W-1:0]        length,
  input  logic                    fr_done,
  input  logic                    fr_tout,
  output logic                    go,
  output frame_cmd_t              cmd,
  output logic [8*ADDR_BYTES-1:0] frame_addr,
  output logic                    busy,
  output logic                    done,
  output logic                    err_range,
  output logic                    err_timeout,
  output logic [LEN_W-1:0]        bytes_done
);
  localparam int ADDR_W = 8 * ADDR_BYTES;
  localparam int SUM_W  = ((ADDR_W > LEN_W) ? ADDR_W : LEN_W) + 1;

  seq_state_t        st;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  rem;
  logic              first_q, issued;
  logic [SUM_W-1:0]  span;
  logic              over;
  seq_state_t        mid_next;

  assign span       = SUM_W'(start_addr) + SUM_W'(length);
  assign over       = span > SUM_W'(DEV_BYTES);
  assign mid_next   = (rem >= LEN_W'(2)) ? SQ_WORD : SQ_WRDI;
  assign go         = (st != SQ_IDLE) && !issued;
  assign busy       = (st != SQ_IDLE);
  assign frame_addr = addr_q;

  always_comb begin
    unique case (st)
      SQ_WREN, SQ_TWREN: cmd = '{op: OP_WREN, use_addr: 1'b0, ndata: 2'd0, poll: 1'b0};
      SQ_WRDI, SQ_TWRDI: cmd = '{op: OP_WRDI, use_addr: 1'b0, ndata: 2'd0, poll: 1'b0};
      SQ_ODD, SQ_TAIL:   cmd = '{op: OP_BYTE, use_addr: 1'b1, ndata: 2'd1, poll: 1'b0};
      SQ_WORD:           cmd = '{op: OP_WORD, use_addr: first_q, ndata: 2'd2, poll: 1'b0};
      default:           cmd = '{op: OP_RDSR, use_addr: 1'b0, ndata: 2'd0, poll: 1'b1};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= SQ_IDLE;
      addr_q      <= '0;
      rem         <= '0;
      first_q     <= 1'b0;
      issued      <= 1'b0;
      done        <= 1'b0;
      err_range   <= 1'b0;
      err_timeout <= 1'b0;
      bytes_done  <= '0;
    end else begin
      done <= 1'b0;
      if (st == SQ_IDLE) begin
        if (start) begin
          err_range   <= 1'b0;
          err_timeout <= 1'b0;
          bytes_done  <= '0;
          if (length == '0) done <= 1'b1;
          else if (over) begin
            err_range <= 1'b1;
            done      <= 1'b1;
          end else begin
            addr_q  <= start_addr;
            rem     <= length;
            first_q <= 1'b1;
            issued  <= 1'b0;
            st      <= SQ_POLL0;
          end
        end
      end else begin
        if (go) issued <= 1'b1;
        if (fr_done) begin
          issued <= 1'b0;
          if (fr_tout) begin
            err_timeout <= 1'b1;
            done        <= 1'b1;
            st          <= SQ_IDLE;
          end else begin
            unique case (st)
              SQ_POLL0: st <= SQ_WREN;
              SQ_WREN:  st <= addr_q[0] ? SQ_ODD : mid_next;
              SQ_ODD, SQ_TAIL: begin
                addr_q     <= addr_q + 1'b1;
                rem        <= rem - 1'b1;
                bytes_done <= bytes_done + 1'b1;
                st         <= (st == SQ_ODD) ? SQ_ODD_POLL : SQ_TAIL_POLL;
              end
              SQ_ODD_POLL, SQ_WORD_POLL: st <= mid_next;
              SQ_WORD: begin
                addr_q     <= addr_q + ADDR_W'(2);
                rem        <= rem - LEN_W'(2);
                bytes_done <= bytes_done + LEN_W'(2);
                first_q    <= 1'b0;
                st         <= SQ_WORD_POLL;
              end
              SQ_WRDI:      st <= SQ_WRDI_POLL;
              SQ_WRDI_POLL: begin
                if (rem == LEN_W'(1)) st <= SQ_TWREN;
                else begin
                  done <= 1'b1;
                  st   <= SQ_IDLE;
                end
              end
              SQ_TWREN:     st <= SQ_TAIL;
              SQ_TAIL_POLL: st <= SQ_TWRDI;
              default: begin
                done <= 1'b1;
                st   <= SQ_IDLE;
              end
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/aai_flash_writer.sv
module aai_flash_writer
  import aai_wr_pkg::*;
#(
  parameter int          ADDR_BYTES = 3,
  parameter int          LEN_W      = 24,
  parameter int          LIMIT_W    = 20,
  parameter int unsigned DEV_BYTES  = 32'd1048576
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [8*ADDR_BYTES-1:0] start_addr,
  input  logic [LEN_W-1:0]        length,
  input  logic [LIMIT_W-1:0]      poll_limit,
  input  logic                    din_valid,
  input  logic [7:0]              din_data,
  output logic                    din_ready,
  output logic                    spi_cs_n,
  output logic                    tx_valid,
  output logic [7:0]              tx_data,
  input  logic                    tx_ready,
  input  logic                    rx_valid,
  input  logic [7:0]              rx_data,
  output logic                    busy,
  output logic                    done,
  output logic                    err_range,
  output logic                    err_timeout,
  output logic [LEN_W-1:0]        bytes_done
);
  logic                    go, fr_done, fr_tout;
  frame_cmd_t              cmd;
  logic [8*ADDR_BYTES-1:0] frame_addr;

  aai_sequencer #(.ADDR_BYTES(ADDR_BYTES), .LEN_W(LEN_W), .DEV_BYTES(DEV_BYTES)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr), .length(length),
    .fr_done(fr_done), .fr_tout(fr_tout), .go(go), .cmd(cmd), .frame_addr(frame_addr),
    .busy(busy), .done(done), .err_range(err_range), .err_timeout(err_timeout),
    .bytes_done(bytes_done)
  );

  aai_frame_engine #(.ADDR_BYTES(ADDR_BYTES), .LIMIT_W(LIMIT_W)) eng_i (
    .clk(clk), .rst_n(rst_n), .go(go), .cmd(cmd), .addr(frame_addr), .limit(poll_limit),
    .fr_done(fr_done), .fr_tout(fr_tout), .cs_n(spi_cs_n), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
    .din_valid(din_valid), .din_data(din_data), .din_ready(din_ready)
  );
endmodule

// File: rtl/aai_flash_writer_chk.sv
module aai_flash_writer_chk #(
  parameter int LEN_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             din_ready,
  input logic             spi_cs_n,
  input logic             tx_valid,
  input logic [7:0]       tx_data,
  input logic             tx_ready,
  input logic             busy,
  input logic             done,
  input logic             err_range,
  input logic             err_timeout,
  input logic [LEN_W-1:0] bytes_done
);
  AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |=> spi_cs_n);                                          // R11
  AST_TX_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !spi_cs_n);                                                // R11
  AST_DIN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    din_ready |-> (tx_ready && !spi_cs_n));                                 // R12
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));            // R12
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);                                                        // R13
  AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);                                                  // R13
  AST_IDLE_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> spi_cs_n);                                                    // R10
  AST_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_range && err_timeout));                                           // R9
  AST_COUNT_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (bytes_done >= $past(bytes_done)));           // R10
endmodule

bind aai_flash_writer aai_flash_writer_chk #(.LEN_W(LEN_W)) chk_i (.*);

// File: tb/aai_flash_writer_tb_top.sv
module aai_flash_writer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] start_addr = '0;
  logic [23:0] length = '0;
  logic [19:0] poll_limit = '0;
  logic        din_valid, din_ready;
  logic [7:0]  din_data;
  logic        spi_cs_n, tx_valid, tx_ready;
  logic [7:0]  tx_data;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        busy, done, err_range, err_timeout;
  logic [23:0] bytes_done;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  aai_flash_writer dut_i (.*);

  // SPI master and flash status model
  logic [7:0] fb [0:63][0:7];
  int         flen [0:63];
  int         nfr = 0, pos = 0, busy_left = 0, prog_cnt = 0, stuck_at = 0;
  bit         stuck = 0;
  logic       prev_cs = 1'b1;
  logic       m_busy = 1'b0;
  logic [7:0] m_resp = 8'hFF;

  assign tx_ready = !m_busy;

  always @(posedge clk) begin
    rx_valid <= 1'b0;
    if (tx_valid && tx_ready) begin
      if (pos < 8 && nfr < 64) fb[nfr][pos] = tx_data;
      if (pos > 0 && fb[nfr][0] == 8'h05) begin
        m_resp = {7'b0, (stuck || busy_left > 0)};
        if (busy_left > 0) busy_left--;
      end else m_resp = 8'hFF;
      pos++;
      m_busy <= 1'b1;
    end else if (m_busy) begin
      rx_valid <= 1'b1;
      rx_data  <= m_resp;
      m_busy   <= 1'b0;
    end
    if (spi_cs_n && !prev_cs && nfr < 64) begin
      flen[nfr] = pos;
      if (fb[nfr][0] == 8'h02 || fb[nfr][0] == 8'hAD) begin
        prog_cnt++;
        busy_left = 2;
        if (stuck_at == prog_cnt) stuck = 1;
      end
      nfr++;
      pos = 0;
    end
    prev_cs = spi_cs_n;
  end

  // data stream source
  logic       src_en = 1'b0, stall_mode = 1'b0, sv = 1'b0;
  logic [7:0] src_base = '0;
  int         src_idx = 0;
  assign din_valid = sv;
  assign din_data  = src_base + 8'(src_idx);

  always @(posedge clk) begin
    if (sv && din_ready) begin
      src_idx <= src_idx + 1;
      if (stall_mode) sv <= 1'b0;
    end else sv <= src_en;
  end

  // expected frames
  logic [7:0] eb [0:63][0:7];
  int         elen [0:63];
  string      etag [0:63];
  int         nexp = 0;

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic add_frame(string tag, int n, logic [7:0] b0, logic [7:0] b1, logic [7:0] b2,
                           logic [7:0] b3, logic [7:0] b4, logic [7:0] b5);
    elen[nexp] = n; etag[nexp] = tag;
    eb[nexp][0] = b0; eb[nexp][1] = b1; eb[nexp][2] = b2;
    eb[nexp][3] = b3; eb[nexp][4] = b4; eb[nexp][5] = b5;
    eb[nexp][6] = 8'h00; eb[nexp][7] = 8'h00;
    nexp++;
  endtask

  task automatic build(logic [23:0] a, int len, logic [7:0] base);
    logic [23:0] cur = a;
    int rem = len;
    int k = 0;
    bit first = 1;
    nexp = 0;
    add_frame("R2", 2, 8'h05, 0, 0, 0, 0, 0);
    add_frame("R2", 1, 8'h06, 0, 0, 0, 0, 0);
    if (cur[0]) begin
      add_frame("R3", 5, 8'h02, cur[23:16], cur[15:8], cur[7:0], base + 8'(k), 0);
      k++; cur++; rem--;
      add_frame("R5", 4, 8'h05, 0, 0, 0, 0, 0);
    end
    while (rem >= 2) begin
      if (first) add_frame("R4", 6, 8'hAD, cur[23:16], cur[15:8], cur[7:0], base + 8'(k), base + 8'(k + 1));
      else       add_frame("R4", 3, 8'hAD, base + 8'(k), base + 8'(k + 1), 0, 0, 0);
      first = 0; k += 2; cur += 2; rem -= 2;
      add_frame("R5", 4, 8'h05, 0, 0, 0, 0, 0);
    end
    add_frame("R6", 1, 8'h04, 0, 0, 0, 0, 0);
    add_frame("R6", 2, 8'h05, 0, 0, 0, 0, 0);
    if (rem == 1) begin
      add_frame("R7", 1, 8'h06, 0, 0, 0, 0, 0);
      add_frame("R7", 5, 8'h02, cur[23:16], cur[15:8], cur[7:0], base + 8'(k), 0);
      add_frame("R7", 4, 8'h05, 0, 0, 0, 0, 0);
      add_frame("R7", 1, 8'h04, 0, 0, 0, 0, 0);
    end
  endtask

  function automatic logic [63:0] pk_act(int i);
    logic [63:0] v = '0;
    for (int j = 0; j < 8; j++) v = {v[55:0], (j < flen[i]) ? fb[i][j] : 8'h00};
    return v;
  endfunction

  function automatic logic [63:0] pk_exp(int i);
    logic [63:0] v = '0;
    for (int j = 0; j < 8; j++) v = {v[55:0], eb[i][j]};
    return v;
  endfunction

  task automatic compare();
    check(nfr == nexp, "R11", "frame count", 64'(nfr), 64'(nexp));
    for (int i = 0; i < nexp && i < nfr; i++) begin
      bit ok = (flen[i] == elen[i]);
      for (int j = 0; j < elen[i] && j < 8; j++) if (fb[i][j] !== eb[i][j]) ok = 0;
      check(ok, etag[i], $sformatf("frame %0d len %0d/%0d", i, flen[i], elen[i]), pk_act(i), pk_exp(i));
    end
  endtask

  task automatic run(logic [23:0] a, int len, int lim, logic [7:0] base, bit stl, int stk, output int waited);
    @(negedge clk);
    nfr = 0; pos = 0; busy_left = 0; prog_cnt = 0; stuck = 0; stuck_at = stk;
    src_base = base; src_idx = 0; stall_mode = stl; src_en = 1'b1;
    start_addr = a; length = 24'(len); poll_limit = 20'(lim);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waited = 0;
    while (!done) begin
      @(negedge clk);
      waited++;
      if (waited > 20000) begin
        check(0, "R13", "done never seen", 0, 1);
        break;
      end
    end
    check(busy == 1'b0, "R13", "busy low with done", 64'(busy), 0);
    @(negedge clk);
    src_en = 1'b0;
    check(done == 1'b0, "R13", "done one cycle", 64'(done), 0);
  endtask

  task automatic t_reset();
    check(spi_cs_n == 1'b1 && tx_valid == 1'b0, "R13", "reset cs/tx", {62'b0, spi_cs_n, tx_valid}, 64'h2);
    check(busy == 1'b0 && done == 1'b0 && din_ready == 1'b0, "R13", "reset busy/done/ready",
          {61'b0, busy, done, din_ready}, 0);
  endtask

  task automatic t_even();
    int w;
    run(24'h000100, 4, 200, 8'h10, 0, 0, w);
    build(24'h000100, 4, 8'h10);
    compare();
    check(fb[2][0] == 8'hAD && fb[2][1] == 8'h00 && fb[2][2] == 8'h01 && fb[2][3] == 8'h00, "R1",
          "word opcode and MSB-first address", {32'b0, fb[2][0], fb[2][1], fb[2][2], fb[2][3]}, 64'hAD000100);
    check(bytes_done == 24'd4 && !err_range && !err_timeout, "R4", "count/flags even", 64'(bytes_done), 4);
  endtask

  task automatic t_odd_stall();
    int w;
    run(24'h012345, 6, 200, 8'h40, 1, 0, w);
    build(24'h012345, 6, 8'h40);
    compare();
    check(bytes_done == 24'd6, "R3", "count odd start", 64'(bytes_done), 6);
    check(src_idx == 6, "R12", "stream bytes consumed", 64'(src_idx), 6);
  endtask

  task automatic t_single_even();
    int w;
    run(24'h000200, 1, 200, 8'h77, 0, 0, w);
    build(24'h000200, 1, 8'h77);
    compare();
    check(bytes_done == 24'd1 && src_idx == 1, "R7", "single byte count", 64'(bytes_done), 1);
  endtask

  task automatic t_zero();
    int w;
    run(24'h000300, 0, 200, 8'h00, 0, 0, w);
    check(w == 0, "R8", "zero length done latency", 64'(w), 0);
    check(nfr == 0 && bytes_done == '0 && !err_range, "R8", "zero length no frame", 64'(nfr), 0);
  endtask

  task automatic t_range();
    int w;
    run(24'h0FFFFE, 3, 200, 8'h20, 0, 0, w);
    check(err_range == 1'b1 && w == 0, "R9", "over range rejected", {63'b0, err_range}, 1);
    check(nfr == 0 && src_idx == 0, "R9", "rejected sends nothing", 64'(nfr), 0);
    run(24'h0FFFFE, 2, 200, 8'h20, 0, 0, w);
    check(err_range == 1'b0, "R9", "range ending at device end accepted", {63'b0, err_range}, 0);
    build(24'h0FFFFE, 2, 8'h20);
    compare();
  endtask

  task automatic t_timeout();
    int w;
    run(24'h000011, 4, 30, 8'h55, 0, 1, w);
    check(err_timeout == 1'b1, "R10", "timeout flag", {63'b0, err_timeout}, 1);
    check(bytes_done == 24'd1, "R10", "bytes before abort", 64'(bytes_done), 1);
    check(nfr == 4 && spi_cs_n == 1'b1, "R10", "frames until abort", 64'(nfr), 4);
    check(fb[2][0] == 8'h02 && fb[3][0] == 8'h05, "R10", "aborted in poll after byte program",
          {48'b0, fb[2][0], fb[3][0]}, 64'h0205);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL R13 watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_even();
    t_odd_stall();
    t_single_even();
    t_zero();
    t_range();
    t_timeout();
    t_even();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule